// File: doc/BRIEF.md
# OSD Pixel Output Driver

This block sits at the end of an on-screen-display pipeline and produces the colour pins and the fast-blanking pin that feed the video mixer. Each dot clock it takes the already-rendered pixel flags for the character foreground, the window and the two edge styles (border and shadow), together with a colour for each layer. It picks one colour by priority and works out whether the fast-blanking pin should be asserted. Both results are registered, so data and output enables change on the same dot-clock edge.

An 8-bit control word, written through a simple write strobe and always readable, sets the following:
- whether the overlay is on;
- which edge style is used;
- how the pins behave while the overlay is off (floating, or driven to idle levels that follow an external blanking-polarity input);
- whether fast blanking covers windows;
- whether fast blanking is forced.

Two bits of the word are not stored. Writing them fires one-cycle clear strobes toward the window-enable bits and the display memory.

Top module: `osd_pixel_drive`

## Requirements
- R1: After reset the control word reads 0x00, rgb_oe and fbk_oe are 0, rgb_o and fbk_o are 0, and both clear strobes are low.
- R2: With the enable bit (bit 7) at 0 and the idle-drive bit (bit 4) at 0, rgb_oe and fbk_oe are 0 and rgb_o and fbk_o are 0. This holds whatever the other control bits and pixel inputs are.
- R3: With bit 7 at 0 and bit 4 at 1, rgb_oe and fbk_oe are 1 and rgb_o is 0. fbk_o is the inverse of fbk_pol: 0 when fbk_pol is 1, and 1 when fbk_pol is 0.
- R4: With bit 7 at 1, both enables are 1. rgb_o takes char_rgb if the character pixel is set; otherwise edge_rgb if an edge pixel is active; otherwise win_rgb if the window pixel is set; otherwise 0.
- R5: The edge pixel is active only when bit 6 is 1. It then follows pix_shadow when bit 5 is 1 and pix_border when bit 5 is 0. The other edge input is ignored.
- R6: With bit 7 at 1 and bit 0 at 0, fbk_o is 1 when a character, an active edge or a window pixel is present. With bit 0 at 1, fbk_o is 1 only for a character or an active edge pixel.
- R7: With bit 7 at 1 and the blank bit (bit 3) at 1, fbk_o is 1 regardless of the pixels.
- R8: A write with bit 2 set raises win_clr_o for exactly one cycle, starting the cycle after the write. A write with bit 1 set does the same on mem_clr_o.
- R9: Every output reflects the pixel inputs, colours, fbk_pol and control word present in the cycle before the edge that updates it, which is one register stage.
- R10: cfg_rdata returns bits 7..3 and bit 0 as last written. Bits 2 and 1 always read back as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 8 | Control word write data |
| cfg_rdata | output | 8 | Control word readback |
| fbk_pol | input | 1 | Fast-blanking polarity, used for the idle level |
| pix_char | input | 1 | Character foreground pixel |
| pix_border | input | 1 | Border edge pixel |
| pix_shadow | input | 1 | Shadow edge pixel |
| pix_win | input | 1 | Window pixel |
| char_rgb | input | 3*COLOR_W | Character colour, channel order R,G,B from MSB |
| edge_rgb | input | 3*COLOR_W | Edge colour |
| win_rgb | input | 3*COLOR_W | Window colour |
| rgb_o | output | 3*COLOR_W | Colour output data |
| rgb_oe | output | 1 | Colour output enable |
| fbk_o | output | 1 | Fast-blanking output data |
| fbk_oe | output | 1 | Fast-blanking output enable |
| win_clr_o | output | 1 | One-cycle clear strobe for window enables |
| mem_clr_o | output | 1 | One-cycle clear strobe for display memory |

## Verification
The properties assume that rst_n is held low long enough for the internal release synchronizer to fill. They also assume that the control-word readback is a faithful view of the stored bits, since they use the readback of the previous cycle as the controlling state. The bench drives every input on the falling edge and issues no writes until several cycles after reset is released, so no write is lost inside the synchronizer window. Pixel patterns are applied one cycle at a time, so each sampled output depends on exactly one previous input set.

// File: rtl/osd_out_pkg.sv
`timescale 1ns/1ps
package osd_out_pkg;

  localparam int unsigned CTRL_W      = 8;
  localparam int unsigned BIT_EN      = 7;
  localparam int unsigned BIT_EDGE    = 6;
  localparam int unsigned BIT_SHADOW  = 5;
  localparam int unsigned BIT_IDLEDRV = 4;
  localparam int unsigned BIT_BLANK   = 3;
  localparam int unsigned BIT_CLRWIN  = 2;
  localparam int unsigned BIT_CLRMEM  = 1;
  localparam int unsigned BIT_FBCHR   = 0;
  localparam int unsigned NUM_CHAN    = 3;

  typedef struct packed {
    logic en;
    logic edge_en;
    logic shadow;
    logic drv_idle;
    logic blank;
    logic fb_char_only;
  } osd_ctrl_t;

endpackage

// File: rtl/osd_rst_sync.sv
`timescale 1ns/1ps
module osd_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/osd_ctrl_reg.sv
`timescale 1ns/1ps
module osd_ctrl_reg
  import osd_out_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [CTRL_W-1:0] wdata,
  output osd_ctrl_t         ctrl,
  output logic [CTRL_W-1:0] rdata,
  output logic              win_clr,
  output logic              mem_clr
);

  osd_ctrl_t ctrl_q;
  osd_ctrl_t ctrl_d;
  logic      win_clr_q;
  logic      win_clr_d;
  logic      mem_clr_q;
  logic      mem_clr_d;

  // decode of the incoming word; stored only when we is high
  always_comb begin
    ctrl_d.en           = wdata[BIT_EN];
    ctrl_d.edge_en      = wdata[BIT_EDGE];
    ctrl_d.shadow       = wdata[BIT_SHADOW];
    ctrl_d.drv_idle     = wdata[BIT_IDLEDRV];
    ctrl_d.blank        = wdata[BIT_BLANK];
    ctrl_d.fb_char_only = wdata[BIT_FBCHR];
    win_clr_d           = we & wdata[BIT_CLRWIN];
    mem_clr_d           = we & wdata[BIT_CLRMEM];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (we) begin
      ctrl_q <= ctrl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_clr_q <= 1'b0;
      mem_clr_q <= 1'b0;
    end else begin
      win_clr_q <= win_clr_d;
      mem_clr_q <= mem_clr_d;
    end
  end

  always_comb begin
    rdata              = '0;
    rdata[BIT_EN]      = ctrl_q.en;
    rdata[BIT_EDGE]    = ctrl_q.edge_en;
    rdata[BIT_SHADOW]  = ctrl_q.shadow;
    rdata[BIT_IDLEDRV] = ctrl_q.drv_idle;
    rdata[BIT_BLANK]   = ctrl_q.blank;
    rdata[BIT_FBCHR]   = ctrl_q.fb_char_only;
  end

  assign ctrl    = ctrl_q;
  assign win_clr = win_clr_q;
  assign mem_clr = mem_clr_q;

endmodule

// File: rtl/osd_pixel_mux.sv
`timescale 1ns/1ps
module osd_pixel_mux
  import osd_out_pkg::*;
#(
  parameter int unsigned COLOR_W = 1,
  localparam int unsigned RGB_W  = NUM_CHAN * COLOR_W
) (
  input  osd_ctrl_t        ctrl,
  input  logic             pix_char,
  input  logic             pix_border,
  input  logic             pix_shadow,
  input  logic             pix_win,
  input  logic [RGB_W-1:0] char_rgb,
  input  logic [RGB_W-1:0] edge_rgb,
  input  logic [RGB_W-1:0] win_rgb,
  output logic [RGB_W-1:0] pix_rgb,
  output logic             fb_active
);

  logic edge_px;

  always_comb begin
    edge_px = ctrl.edge_en & (ctrl.shadow ? pix_shadow : pix_border);
  end

  // layer priority: character, then edge, then window
  always_comb begin
    if (pix_char) begin
      pix_rgb = char_rgb;
    end else if (edge_px) begin
      pix_rgb = edge_rgb;
    end else if (pix_win) begin
      pix_rgb = win_rgb;
    end else begin
      pix_rgb = '0;
    end
  end

  always_comb begin
    fb_active = pix_char | edge_px | (~ctrl.fb_char_only & pix_win);
  end

endmodule

// File: rtl/osd_out_stage.sv
`timescale 1ns/1ps
module osd_out_stage
  import osd_out_pkg::*;
#(
  parameter int unsigned COLOR_W = 1,
  localparam int unsigned RGB_W  = NUM_CHAN * COLOR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  osd_ctrl_t        ctrl,
  input  logic [RGB_W-1:0] pix_rgb,
  input  logic             fb_active,
  input  logic             fbk_pol,
  output logic [RGB_W-1:0] rgb_o,
  output logic             rgb_oe,
  output logic             fbk_o,
  output logic             fbk_oe
);

  logic drive;
  logic oe_d;
  logic oe_q;
  logic fbk_d;
  logic fbk_q;
  logic fbk_oe_q;

  always_comb begin
    drive = ctrl.en | ctrl.drv_idle;
    oe_d  = drive;
    if (ctrl.en) begin
      fbk_d = ctrl.blank | fb_active;
    end else if (ctrl.drv_idle) begin
      fbk_d = ~fbk_pol;
    end else begin
      fbk_d = 1'b0;
    end
  end

  for (genvar ch = 0; ch < NUM_CHAN; ch++) begin : g_chan
    logic [COLOR_W-1:0] chan_d;
    logic [COLOR_W-1:0] chan_q;

    always_comb begin
      chan_d = ctrl.en ? pix_rgb[ch*COLOR_W +: COLOR_W] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chan_q <= '0;
      end else begin
        chan_q <= chan_d;
      end
    end

    assign rgb_o[ch*COLOR_W +: COLOR_W] = chan_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q     <= 1'b0;
      fbk_oe_q <= 1'b0;
      fbk_q    <= 1'b0;
    end else begin
      oe_q     <= oe_d;
      fbk_oe_q <= oe_d;
      fbk_q    <= fbk_d;
    end
  end

  assign rgb_oe = oe_q;
  assign fbk_oe = fbk_oe_q;
  assign fbk_o  = fbk_q;

endmodule

// File: rtl/osd_pixel_drive.sv
`timescale 1ns/1ps
module osd_pixel_drive
  import osd_out_pkg::*;
#(
  parameter int unsigned COLOR_W    = 1,
  parameter int unsigned RST_STAGES = 2,
  localparam int unsigned RGB_W     = NUM_CHAN * COLOR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CTRL_W-1:0] cfg_wdata,
  output logic [CTRL_W-1:0] cfg_rdata,
  input  logic              fbk_pol,
  input  logic              pix_char,
  input  logic              pix_border,
  input  logic              pix_shadow,
  input  logic              pix_win,
  input  logic [RGB_W-1:0]  char_rgb,
  input  logic [RGB_W-1:0]  edge_rgb,
  input  logic [RGB_W-1:0]  win_rgb,
  output logic [RGB_W-1:0]  rgb_o,
  output logic              rgb_oe,
  output logic              fbk_o,
  output logic              fbk_oe,
  output logic              win_clr_o,
  output logic              mem_clr_o
);

  logic             rst_int_n;
  osd_ctrl_t        ctrl;
  logic [RGB_W-1:0] pix_rgb;
  logic             fb_active;

  osd_rst_sync #(
    .STAGES(RST_STAGES)
  ) u_rst_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_int_n)
  );

  osd_ctrl_reg u_ctrl (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .we     (cfg_we),
    .wdata  (cfg_wdata),
    .ctrl   (ctrl),
    .rdata  (cfg_rdata),
    .win_clr(win_clr_o),
    .mem_clr(mem_clr_o)
  );

  osd_pixel_mux #(
    .COLOR_W(COLOR_W)
  ) u_mux (
    .ctrl      (ctrl),
    .pix_char  (pix_char),
    .pix_border(pix_border),
    .pix_shadow(pix_shadow),
    .pix_win   (pix_win),
    .char_rgb  (char_rgb),
    .edge_rgb  (edge_rgb),
    .win_rgb   (win_rgb),
    .pix_rgb   (pix_rgb),
    .fb_active (fb_active)
  );

  osd_out_stage #(
    .COLOR_W(COLOR_W)
  ) u_out (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .ctrl     (ctrl),
    .pix_rgb  (pix_rgb),
    .fb_active(fb_active),
    .fbk_pol  (fbk_pol),
    .rgb_o    (rgb_o),
    .rgb_oe   (rgb_oe),
    .fbk_o    (fbk_o),
    .fbk_oe   (fbk_oe)
  );

endmodule

// File: rtl/osd_pixel_drive_chk.sv
`timescale 1ns/1ps
module osd_pixel_drive_chk #(
  parameter int unsigned COLOR_W = 1,
  localparam int unsigned RGB_W  = 3 * COLOR_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic [7:0]       cfg_wdata,
  input logic [7:0]       cfg_rdata,
  input logic             fbk_pol,
  input logic             pix_char,
  input logic [RGB_W-1:0] char_rgb,
  input logic [RGB_W-1:0] rgb_o,
  input logic             rgb_oe,
  input logic             fbk_o,
  input logic             fbk_oe,
  input logic             win_clr_o,
  input logic             mem_clr_o
);

  AST_FLOAT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!rgb_oe) |-> (rgb_o == '0 && !fbk_oe && !fbk_o)); // R2

  AST_IDLE_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_rdata[7] && cfg_rdata[4]) |=>
      (rgb_oe && fbk_oe && rgb_o == '0 && fbk_o == !$past(fbk_pol))); // R3

  AST_ON_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[7] |=> (rgb_oe && fbk_oe)); // R4

  AST_CHAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[7] && pix_char) |=> (rgb_o == $past(char_rgb) && fbk_o)); // R4

  AST_FORCED_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[7] && cfg_rdata[3]) |=> fbk_o); // R7

  AST_WINCLR_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    win_clr_o |-> $past(cfg_we && cfg_wdata[2])); // R8

  AST_MEMCLR_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_clr_o |-> $past(cfg_we && cfg_wdata[1])); // R8

  AST_STROBE_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[2:1] == 2'b00); // R10

endmodule

bind osd_pixel_drive osd_pixel_drive_chk #(.COLOR_W(COLOR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_we   (cfg_we),
  .cfg_wdata(cfg_wdata),
  .cfg_rdata(cfg_rdata),
  .fbk_pol  (fbk_pol),
  .pix_char (pix_char),
  .char_rgb (char_rgb),
  .rgb_o    (rgb_o),
  .rgb_oe   (rgb_oe),
  .fbk_o    (fbk_o),
  .fbk_oe   (fbk_oe),
  .win_clr_o(win_clr_o),
  .mem_clr_o(mem_clr_o)
);

// File: tb/osd_pixel_drive_tb.sv
`timescale 1ns/1ps
module osd_pixel_drive_tb;

  localparam int unsigned CW = 1;
  localparam int unsigned RW = 3 * CW;

  logic          clk;
  logic          rst_n;
  logic          cfg_we;
  logic [7:0]    cfg_wdata;
  logic [7:0]    cfg_rdata;
  logic          fbk_pol;
  logic          pix_char;
  logic          pix_border;
  logic          pix_shadow;
  logic          pix_win;
  logic [RW-1:0] char_rgb;
  logic [RW-1:0] edge_rgb;
  logic [RW-1:0] win_rgb;
  logic [RW-1:0] rgb_o;
  logic          rgb_oe;
  logic          fbk_o;
  logic          fbk_oe;
  logic          win_clr_o;
  logic          mem_clr_o;

  int checks;
  int fails;
  bit done;

  osd_pixel_drive #(.COLOR_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .fbk_pol(fbk_pol), .pix_char(pix_char),
    .pix_border(pix_border), .pix_shadow(pix_shadow), .pix_win(pix_win),
    .char_rgb(char_rgb), .edge_rgb(edge_rgb), .win_rgb(win_rgb),
    .rgb_o(rgb_o), .rgb_oe(rgb_oe), .fbk_o(fbk_o), .fbk_oe(fbk_oe),
    .win_clr_o(win_clr_o), .mem_clr_o(mem_clr_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // write completes at the next rising edge; returns at the following falling edge
  task automatic wr(input logic [7:0] v);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_wdata = v;
    @(negedge clk);
    cfg_we    = 1'b0;
    cfg_wdata = 8'h00;
  endtask

  // apply one pixel set at a falling edge, return after the next rising edge
  task automatic px(input logic c, input logic bd, input logic sh, input logic w);
    pix_char   = c;
    pix_border = bd;
    pix_shadow = sh;
    pix_win    = w;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1", "rdata", cfg_rdata, 8'h00);
    chk("R1", "rgb_oe", rgb_oe, 0);
    chk("R1", "fbk_oe", fbk_oe, 0);
    chk("R1", "rgb_o", rgb_o, 0);
    chk("R1", "fbk_o", fbk_o, 0);
    chk("R1", "strobes", {win_clr_o, mem_clr_o}, 0);
  endtask

  task automatic t_float;
    wr(8'h69); // enable 0, idle-drive 0, other bits set
    px(1, 1, 1, 1);
    chk("R2", "rgb_oe", rgb_oe, 0);
    chk("R2", "fbk_oe", fbk_oe, 0);
    chk("R2", "rgb_o", rgb_o, 0);
    chk("R2", "fbk_o", fbk_o, 0);
  endtask

  task automatic t_idle_drive;
    wr(8'h10);
    fbk_pol = 1'b1;
    px(1, 0, 0, 1);
    chk("R3", "rgb_oe", rgb_oe, 1);
    chk("R3", "fbk_oe", fbk_oe, 1);
    chk("R3", "rgb_o", rgb_o, 0);
    chk("R3", "fbk_o pol1", fbk_o, 0);
    fbk_pol = 1'b0;
    px(1, 0, 0, 1);
    chk("R3", "fbk_o pol0", fbk_o, 1);
  endtask

  task automatic t_priority;
    wr(8'hC0); // enable, border edge
    px(1, 1, 0, 1);
    chk("R4", "char over all", rgb_o, int'(char_rgb));
    chk("R4", "rgb_oe", rgb_oe, 1);
    px(0, 1, 0, 1);
    chk("R4", "edge over win", rgb_o, int'(edge_rgb));
    px(0, 0, 0, 1);
    chk("R4", "win only", rgb_o, int'(win_rgb));
    px(0, 0, 0, 0);
    chk("R4", "nothing", rgb_o, 0);
  endtask

  task automatic t_edge_sel;
    wr(8'h80); // edge effect off
    px(0, 1, 1, 0);
    chk("R5", "edge off", rgb_o, 0);
    wr(8'hC0); // border
    px(0, 1, 0, 0);
    chk("R5", "border used", rgb_o, int'(edge_rgb));
    px(0, 0, 1, 0);
    chk("R5", "shadow ignored", rgb_o, 0);
    wr(8'hE0); // shadow
    px(0, 0, 1, 0);
    chk("R5", "shadow used", rgb_o, int'(edge_rgb));
    px(0, 1, 0, 0);
    chk("R5", "border ignored", rgb_o, 0);
  endtask

  task automatic t_fbk_mode;
    wr(8'hC0);
    px(0, 0, 0, 1);
    chk("R6", "win blanks mode0", fbk_o, 1);
    px(0, 1, 0, 0);
    chk("R6", "edge blanks mode0", fbk_o, 1);
    px(0, 0, 0, 0);
    chk("R6", "idle mode0", fbk_o, 0);
    wr(8'hC1);
    px(0, 0, 0, 1);
    chk("R6", "win no blank mode1", fbk_o, 0);
    chk("R6", "win colour mode1", rgb_o, int'(win_rgb));
    px(1, 0, 0, 0);
    chk("R6", "char blanks mode1", fbk_o, 1);
  endtask

  task automatic t_blank;
    wr(8'h89);
    px(0, 0, 0, 0);
    chk("R7", "forced blank", fbk_o, 1);
    chk("R7", "rgb with blank", rgb_o, 0);
  endtask

  task automatic t_strobes;
    wr(8'h84);
    chk("R8", "win_clr high", win_clr_o, 1);
    chk("R8", "mem_clr quiet", mem_clr_o, 0);
    chk("R10", "rdata after clrwin", cfg_rdata, 8'h80);
    @(negedge clk);
    chk("R8", "win_clr one cycle", win_clr_o, 0);
    wr(8'h82);
    chk("R8", "mem_clr high", mem_clr_o, 1);
    chk("R8", "win_clr quiet", win_clr_o, 0);
    @(negedge clk);
    chk("R8", "mem_clr one cycle", mem_clr_o, 0);
    wr(8'hFF);
    chk("R10", "rdata all", cfg_rdata, 8'hF9);
  endtask

  task automatic t_latency;
    wr(8'h80);
    px(0, 0, 0, 0);
    pix_char = 1'b1;
    #1;
    chk("R9", "no change before edge", rgb_o, 0);
    @(negedge clk);
    chk("R9", "change after edge", rgb_o, int'(char_rgb));
    wr(8'h00); // control captured at the edge just passed
    chk("R9", "oe holds one edge", rgb_oe, 1);
    @(negedge clk);
    chk("R9", "oe drops next edge", rgb_oe, 0);
    pix_char = 1'b0;
  endtask

  initial begin
    checks = 0; fails = 0; done = 1'b0;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = 8'h00; fbk_pol = 1'b0;
    pix_char = 1'b0; pix_border = 1'b0; pix_shadow = 1'b0; pix_win = 1'b0;
    char_rgb = 3'b101; edge_rgb = 3'b010; win_rgb = 3'b110;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_float;
    t_idle_drive;
    t_priority;
    t_edge_sel;
    t_fbk_mode;
    t_blank;
    t_strobes;
    t_latency;
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule